// File: doc/BRIEF.md
# Pointer-Indexed Buffer Access Port

This block connects a byte-wide host register port to a 1024-byte packet buffer. The buffer is not mapped into the host address space. The host loads a 10-bit pointer through two register bytes and then moves data one byte at a time through a single data register.

Reads are prefetched into a holding register, and writes are posted from that same register. Neither kind of host access waits for the buffer. An optional auto-increment mode moves the pointer after each accepted data access. Because the pointer reads back at any time, the host can count how many transfers have completed.

A network-side request port shares the buffer with the host through a fixed-priority arbiter that has a one-slot fairness rule. A slow-arbitration input halves the rate at which the arbiter grants the buffer.

Top module: `buf_access_port`

## Requirements
- R1: After reset the pointer is 000h and both mode bits are 0. Register offsets 2, 3 and 4 read 00h, and `host_notrdy_o` is low.
- R2: The registers sit at offset 2 (pointer high), offset 3 (pointer low) and offset 4 (data).
  - A write to offset 2 only stages a value and changes nothing that can be read back.
  - A write to offset 3 commits the pointer as {staged bits 1:0, written byte}. It also commits the mode: staged bit 7 selects read (1) or write (0), and staged bit 6 enables auto-increment.
- R3: A pointer commit in read mode fetches the addressed byte into the holding register. Offset 4 returns that byte once `host_notrdy_o` is low.
- R4: `host_notrdy_o` goes high on the clock edge that commits a read-mode pointer. It stays high while a prefetch or a posted write is pending. A data read in the cycle right after the commit therefore sees it high. Any data access made while it is high is ignored and leaves the pointer unchanged.
- R5: In read mode with auto-increment, each accepted data read advances the pointer by one and fetches the next byte. After N reads from start S, the pointer reads back S+N.
- R6: In write mode, an accepted data write is held in the holding register and then written to the buffer at the pointer. With auto-increment on, the pointer then advances by one.
- R7: With auto-increment off, data accesses never move the pointer, and repeated reads return the same byte.
- R8: A data write in read mode does not change the buffer or the pointer. A data read in write mode does not move the pointer.
- R9: An increment from 3FFh wraps the pointer to 000h.
- R10: The arbiter grants at most one requester per cycle, and the network port has priority. A host operation that loses a slot wins the next one. Network read data appears on `net_rdata_o` one cycle after the grant.
- R11: When `slow_arb_i` is high, grants occur at most every other cycle, and every pending host prefetch and write still completes in order.
- R12: Pointer high reads back as {mode read, auto-increment, 0000b, pointer bits 9:8}. Offset 3 returns pointer bits 7:0. All other offsets read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_arb_i | input | 1 | Halve the arbiter grant rate |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe |
| host_addr_i | input | 3 | Host register offset |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for the addressed register |
| host_notrdy_o | output | 1 | A prefetch or posted write is pending |
| net_req_i | input | 1 | Network-side buffer request |
| net_we_i | input | 1 | Network request is a write |
| net_addr_i | input | 10 | Network buffer address |
| net_wdata_i | input | 8 | Network write data |
| net_gnt_o | output | 1 | Network request granted this cycle |
| net_rdata_o | output | 8 | Network read data, valid the cycle after a read grant |

## Verification
The assertions assume the host never asserts read and write strobes in the same cycle. They also assume the network side holds its request stable until it is granted.

The bench's host tasks drive exactly one strobe per access. The network driver keeps its request, address and data until it samples a grant. The network side only touches buffer bytes 100h to 1FFh and the host avoids that range, so the order of their writes never matters to the expected values.

// File: rtl/bap_pkg.sv
package bap_pkg;
  localparam int unsigned DW = 8;
  localparam logic [2:0] OFF_PHI  = 3'd2;
  localparam logic [2:0] OFF_PLO  = 3'd3;
  localparam logic [2:0] OFF_DATA = 3'd4;
endpackage

// File: rtl/bap_arbiter.sv
module bap_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  input  logic net_req_i,
  input  logic host_req_i,
  output logic net_gnt_o,
  output logic host_gnt_o
);
  logic phase_q, host_wait_q, slot;

  assign slot       = !slow_i || phase_q;
  assign net_gnt_o  = slot && net_req_i && !(host_req_i && host_wait_q);
  assign host_gnt_o = slot && host_req_i && !net_gnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= 1'b0;
      host_wait_q <= 1'b0;
    end else begin
      phase_q <= !phase_q;
      if (host_gnt_o)                   host_wait_q <= 1'b0;
      else if (host_req_i && net_gnt_o) host_wait_q <= 1'b1;
    end
  end

  p_one_gnt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(net_gnt_o && host_gnt_o));
  // R10: a host op that lost a slot takes the next one
  p_host_bounded_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wait_q && host_req_i && slot) |-> host_gnt_o);
  p_slow_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_i && (net_gnt_o || host_gnt_o)) |=> !(slow_i && (net_gnt_o || host_gnt_o)));
endmodule

// File: rtl/bap_ram.sv
module bap_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/bap_host_port.sv
module bap_host_port
  import bap_pkg::*;
#(
  parameter int unsigned AW = 10,
  localparam int unsigned HW = AW - 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          notrdy_o,
  output logic          req_o,
  output logic          req_we_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          gnt_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [AW-1:0] ptr_q, wr_addr_q;
  logic [HW-1:0] stage_hi_q;
  logic          stage_rd_q, stage_ainc_q, mode_rd_q, mode_ainc_q;
  logic [DW-1:0] hold_q;
  logic          pf_pend_q, wr_pend_q;
  logic          ld_hi, ld_lo, d_rd, d_wr;

  assign notrdy_o = pf_pend_q || wr_pend_q;
  assign ld_hi = wr_i && addr_i == OFF_PHI;
  assign ld_lo = wr_i && addr_i == OFF_PLO;
  assign d_rd  = rd_i && addr_i == OFF_DATA && !notrdy_o && mode_rd_q;
  assign d_wr  = wr_i && addr_i == OFF_DATA && !notrdy_o && !mode_rd_q;

  // posted write drains before any prefetch queued behind it
  assign req_o       = pf_pend_q || wr_pend_q;
  assign req_we_o    = wr_pend_q;
  assign req_addr_o  = wr_pend_q ? wr_addr_q : ptr_q;
  assign req_wdata_o = hold_q;

  always_comb begin
    unique case (addr_i)
      OFF_PHI:  rdata_o = {mode_rd_q, mode_ainc_q, {(6-HW){1'b0}}, ptr_q[AW-1:8]};
      OFF_PLO:  rdata_o = ptr_q[7:0];
      OFF_DATA: rdata_o = hold_q;
      default:  rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q        <= '0;
      wr_addr_q    <= '0;
      stage_hi_q   <= '0;
      stage_rd_q   <= 1'b0;
      stage_ainc_q <= 1'b0;
      mode_rd_q    <= 1'b0;
      mode_ainc_q  <= 1'b0;
      hold_q       <= '0;
      pf_pend_q    <= 1'b0;
      wr_pend_q    <= 1'b0;
    end else begin
      if (gnt_i) begin
        if (wr_pend_q) wr_pend_q <= 1'b0;
        else begin
          pf_pend_q <= 1'b0;
          hold_q    <= mem_rdata_i;
        end
      end
      if (ld_hi) begin
        stage_rd_q   <= wdata_i[7];
        stage_ainc_q <= wdata_i[6];
        stage_hi_q   <= wdata_i[HW-1:0];
      end
      if (ld_lo) begin
        ptr_q       <= {stage_hi_q, wdata_i};
        mode_rd_q   <= stage_rd_q;
        mode_ainc_q <= stage_ainc_q;
        if (stage_rd_q) pf_pend_q <= 1'b1;
      end
      if (d_rd && mode_ainc_q) begin
        ptr_q     <= ptr_q + 1'b1;
        pf_pend_q <= 1'b1;
      end
      if (d_wr) begin
        hold_q    <= wdata_i;
        wr_addr_q <= ptr_q;
        wr_pend_q <= 1'b1;
        if (mode_ainc_q) ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  p_load_notrdy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_lo && stage_rd_q) |=> notrdy_o);
  p_busy_ptr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && addr_i == OFF_DATA && notrdy_o) |=> $stable(ptr_q));
  p_dir_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_DATA && mode_rd_q && !wr_pend_q) |=> !wr_pend_q);
  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_rd && mode_ainc_q && ptr_q == '1) |=> ptr_q == '0);
  p_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));
endmodule

// File: rtl/buf_access_port.sv
module buf_access_port
  import bap_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slow_arb_i,
  input  logic          host_wr_i,
  input  logic          host_rd_i,
  input  logic [2:0]    host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          host_notrdy_o,
  input  logic          net_req_i,
  input  logic          net_we_i,
  input  logic [AW-1:0] net_addr_i,
  input  logic [DW-1:0] net_wdata_i,
  output logic          net_gnt_o,
  output logic [DW-1:0] net_rdata_o
);
  logic          h_req, h_we, h_gnt;
  logic [AW-1:0] h_addr, m_addr;
  logic [DW-1:0] h_wdata, m_wdata, m_rdata;
  logic          m_we;

  bap_host_port #(.AW(AW)) u_host (
    .clk_i, .rst_ni,
    .wr_i(host_wr_i), .rd_i(host_rd_i), .addr_i(host_addr_i), .wdata_i(host_wdata_i),
    .rdata_o(host_rdata_o), .notrdy_o(host_notrdy_o),
    .req_o(h_req), .req_we_o(h_we), .req_addr_o(h_addr), .req_wdata_o(h_wdata),
    .gnt_i(h_gnt), .mem_rdata_i(m_rdata)
  );

  bap_arbiter u_arb (
    .clk_i, .rst_ni, .slow_i(slow_arb_i),
    .net_req_i, .host_req_i(h_req),
    .net_gnt_o, .host_gnt_o(h_gnt)
  );

  assign m_addr  = net_gnt_o ? net_addr_i : h_addr;
  assign m_wdata = net_gnt_o ? net_wdata_i : h_wdata;
  assign m_we    = (net_gnt_o && net_we_i) || (h_gnt && h_we);

  bap_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i, .we_i(m_we), .addr_i(m_addr), .wdata_i(m_wdata), .rdata_o(m_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      net_rdata_o <= '0;
    else if (net_gnt_o && !net_we_i)  net_rdata_o <= m_rdata;
  end

  p_net_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_req_i && !net_gnt_o && !slow_arb_i) |-> h_gnt);
endmodule

// File: tb/buf_access_port_bench.sv
`timescale 1ns/1ps
module buf_access_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slow = 1'b0, h_wr = 1'b0, h_rd = 1'b0;
  logic [2:0] h_addr = '0;
  logic [7:0] h_wdata = '0, h_rdata, n_wdata = '0, n_rdata;
  logic h_nr, n_req = 1'b0, n_we = 1'b0, n_gnt;
  logic [9:0] n_addr = '0;

  always #10 clk = !clk;

  buf_access_port u_buf_access_port (
    .clk_i(clk), .rst_ni(rst_n), .slow_arb_i(slow),
    .host_wr_i(h_wr), .host_rd_i(h_rd), .host_addr_i(h_addr), .host_wdata_i(h_wdata),
    .host_rdata_o(h_rdata), .host_notrdy_o(h_nr),
    .net_req_i(n_req), .net_we_i(n_we), .net_addr_i(n_addr), .net_wdata_i(n_wdata),
    .net_gnt_o(n_gnt), .net_rdata_o(n_rdata)
  );

  logic [7:0] model [1024];
  int nvec = 0, nerr = 0;
  int net_mode = 0;
  bit done = 0;

  function automatic logic [7:0] exp_hi(bit rd, bit ainc, logic [9:0] p);
    return {rd, ainc, 4'b0000, p[9:8]};
  endfunction

  function automatic logic [9:0] pick_host_start(int len);
    int unsigned r = $urandom % 2;
    if (r == 0) return 10'($urandom % (256 - len));
    return 10'(10'h200 + $urandom % (512 - len));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic host_wr(logic [2:0] a, logic [7:0] d);
    h_addr = a; h_wdata = d; h_wr = 1'b1;
    tick();
    h_wr = 1'b0;
  endtask

  task automatic host_rd(logic [2:0] a, output logic [7:0] d, output logic nr);
    h_addr = a; h_rd = 1'b1;
    @(negedge clk); d = h_rdata; nr = h_nr;
    tick();
    h_rd = 1'b0;
  endtask

  task automatic wait_rdy();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!h_nr) break;
      if (i == 99) chk("R11 ready timeout", 1, 0);
    end
    tick();
  endtask

  task automatic set_ptr(logic [9:0] a, bit rd, bit ainc);
    host_wr(3'd2, exp_hi(rd, ainc, a));
    host_wr(3'd3, a[7:0]);
  endtask

  task automatic chk_ptr(string req, logic [9:0] p, bit rd, bit ainc);
    logic [7:0] d; logic nr;
    host_rd(3'd3, d, nr); chk({req, " ptr lo"}, d, p[7:0]);
    host_rd(3'd2, d, nr); chk({req, " ptr hi"}, d, exp_hi(rd, ainc, p));
  endtask

  task automatic rd_burst(string req, logic [9:0] s, int len);
    logic [7:0] d; logic nr;
    set_ptr(s, 1, 1);
    for (int i = 0; i < len; i++) begin
      wait_rdy();
      host_rd(3'd4, d, nr);
      chk(req, d, model[10'(s + i)]);
    end
    chk_ptr(req, 10'(s + len), 1, 1);
  endtask

  task automatic wr_burst(string req, logic [9:0] s, int len);
    logic [7:0] v;
    set_ptr(s, 0, 1);
    for (int i = 0; i < len; i++) begin
      v = 8'($urandom);
      wait_rdy();
      host_wr(3'd4, v);
      model[10'(s + i)] = v;
    end
    chk_ptr(req, 10'(s + len), 0, 1);
  endtask

  // network-side driver and R10 read checker; bytes 100h..1FFh only
  initial begin : net_drv
    bit pend; logic [7:0] nexp; bit granted;
    pend = 0;
    forever begin
      @(negedge clk);
      granted = n_req && n_gnt;
      if (granted) begin
        if (n_we) model[n_addr] = n_wdata;
        else begin pend = 1; nexp = model[n_addr]; end
      end
      tick();
      if (pend) begin chk("R10 net read data", n_rdata, nexp); pend = 0; end
      if (granted || !n_req) begin
        n_req   = (net_mode == 2) || (net_mode == 1 && ($urandom % 2) == 1);
        n_we    = $urandom % 2;
        n_addr  = 10'(10'h100 + $urandom % 256);
        n_wdata = 8'($urandom);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nvec++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d, d0; logic nr;
    int pairs, grants;
    bit prev;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    @(negedge clk); chk("R1 notrdy", h_nr, 0);
    tick();
    chk_ptr("R1", 10'h000, 0, 0);
    host_rd(3'd4, d, nr); chk("R1 data", d, 8'h00);

    // fill whole buffer through posted writes
    set_ptr(10'h000, 0, 1);
    for (int i = 0; i < 1024; i++) begin
      d = 8'($urandom);
      wait_rdy();
      host_wr(3'd4, d);
      model[i] = d;
    end
    chk_ptr("R6 fill wrap", 10'h000, 0, 1);

    // R2 staging: high write alone changes nothing visible
    set_ptr(10'h012, 1, 0); wait_rdy();
    host_wr(3'd2, exp_hi(0, 1, 10'h3FF));
    chk_ptr("R2 staged only", 10'h012, 1, 0);
    host_wr(3'd3, 8'h45);
    chk_ptr("R2 commit", 10'h345, 0, 1);

    // R12 unmapped offsets
    host_rd(3'd0, d, nr); chk("R12 offset 0", d, 8'h00);
    host_rd(3'd5, d, nr); chk("R12 offset 5", d, 8'h00);
    host_rd(3'd7, d, nr); chk("R12 offset 7", d, 8'h00);

    // R4 read too early, then R3 prefetch
    set_ptr(10'h2A0, 1, 1);
    host_rd(3'd4, d, nr); chk("R4 early read flagged", nr, 1);
    wait_rdy();
    chk_ptr("R4 early read ignored", 10'h2A0, 1, 1);
    set_ptr(10'h2A0, 1, 1); wait_rdy();
    host_rd(3'd4, d, nr); chk("R3 prefetch data", d, model[10'h2A0]);

    // R5 streaming read
    rd_burst("R5 stream read", 10'h050, 6);

    // R6 streaming write then readback
    wr_burst("R6 posted write", 10'h300, 5);
    rd_burst("R6 readback", 10'h300, 5);

    // R7 no auto-increment
    set_ptr(10'h077, 1, 0);
    for (int i = 0; i < 3; i++) begin
      wait_rdy(); host_rd(3'd4, d, nr); chk("R7 same byte", d, model[10'h077]);
    end
    chk_ptr("R7 ptr fixed", 10'h077, 1, 0);

    // R8 direction mismatch
    set_ptr(10'h0C0, 1, 1); wait_rdy();
    host_wr(3'd4, ~model[10'h0C0]);
    chk_ptr("R8 write in read mode ptr", 10'h0C0, 1, 1);
    set_ptr(10'h0C0, 1, 0); wait_rdy();
    host_rd(3'd4, d, nr); chk("R8 buffer untouched", d, model[10'h0C0]);
    set_ptr(10'h0C8, 0, 1); wait_rdy();
    host_rd(3'd4, d, nr);
    chk_ptr("R8 read in write mode ptr", 10'h0C8, 0, 1);

    // R9 wrap in both directions
    wr_burst("R9 write wrap", 10'h3FE, 3);
    rd_burst("R9 read wrap", 10'h3FD, 4);

    // R10 net contention: host still served within two cycles
    net_mode = 2;
    repeat (4) tick();
    set_ptr(10'h0A5, 1, 0);
    tick(); tick();
    @(negedge clk); chk("R10 host served one slot late", h_nr, 0);
    tick();
    host_rd(3'd4, d, nr); chk("R10 contended data", d, model[10'h0A5]);

    // R11 slow arbitration spacing
    slow = 1'b1;
    pairs = 0; grants = 0; prev = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (n_gnt) grants++;
      if (n_gnt && prev) pairs++;
      prev = n_gnt;
      tick();
    end
    chk("R11 no back-to-back grants", pairs, 0);
    chk("R11 net still granted", grants > 10, 1);
    wr_burst("R11 slow write", 10'h220, 6);
    rd_burst("R11 slow read", 10'h220, 6);

    // random mix
    net_mode = 1;
    for (int k = 0; k < 60; k++) begin
      int len;
      logic [9:0] s;
      slow = ($urandom % 4) == 0;
      len = 1 + $urandom % 8;
      s = pick_host_start(len);
      if ($urandom % 2) wr_burst("R6 random write", s, len);
      else              rd_burst("R5 random read", s, len);
    end
    slow = 1'b0;
    set_ptr(10'h010, 1, 0); wait_rdy();
    d0 = model[10'h010];
    host_rd(3'd4, d, nr); chk("R3 final fetch", d, d0);

    net_mode = 0;
    repeat (4) tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule